// File: doc/BRIEF.md
# Serial NOR flash whole-array wipe controller

This block is the device-side command logic of a small serial NOR flash. It handles the whole-array erase only. A host selects the device by pulling chip select low. It then clocks in an 8-bit instruction in SPI mode 0: the device samples on the rising edge of the serial clock, most significant bit first. The block keeps two status bits, write-in-progress and the write-enable latch. It runs a self-timed wipe that writes FFh into every byte of a small on-block array. It answers a status-read instruction on the serial output. All serial inputs are brought into the system clock domain before use.

The wipe is accepted only under four conditions: the write-enable latch is set, no wipe is running, the protection input is low, and chip select rises after exactly eight instruction bits. The wipe lasts a parameterised number of system-clock cycles. The write-enable latch drops at the midpoint of the wipe. An active-low reset aborts a running wipe and leaves the array contents undefined. After reset is released, the serial side ignores every instruction for a parameterised recovery interval. A plain load port and read port give the surrounding logic direct access to the array.

Top module: `nor_bulk_wipe`

## Requirements
- R1: An accepted wipe writes FFh into every byte of the array, so every address reads FFh on `rd_data` after write-in-progress returns to 0.
- R2: A wipe instruction (C7h) starts only if the write-enable latch is 1. The latch is set by a write-enable instruction (06h) when chip select rises after exactly eight bits and no wipe is running.
- R3: An instruction executes only if chip select rises after exactly eight clocked bits. With 7, 9 or 16 bits the wipe does not start.
- R4: Write-in-progress goes to 1 in the cycle after the synchronised rising edge of chip select that accepts a wipe. It stays 1 for ERASE_CYC system-clock cycles and then returns to 0.
- R5: The write-enable latch is cleared ERASE_CYC/2 cycles into a wipe, while write-in-progress is still 1.
- R6: A wipe or write-enable instruction received while a wipe runs is ignored. The running wipe ends at its original time.
- R7: While `wp_any` is 1 a wipe instruction is ignored, and the write-enable latch keeps its value.
- R8: Reset low aborts a running wipe and clears both status bits. For REC_CYC cycles after reset is released, every instruction is ignored.
- R9: After the eight bits of the status-read instruction (05h), `miso` shifts out the byte {6'b0, latch, in-progress}, MSB first. Each bit changes after a falling serial-clock edge. The byte repeats for as long as the host keeps clocking.
- R10: `miso` is high impedance whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; aborts a wipe |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data into the device |
| miso | output | 1 | Serial data out of the device, high impedance when deselected |
| wp_any | input | 1 | High when any region is write-protected |
| ld_en | input | 1 | Direct array write enable |
| ld_addr | input | $clog2(DEPTH) | Direct array write address |
| ld_data | input | 8 | Direct array write data |
| rd_addr | input | $clog2(DEPTH) | Array read address |
| rd_data | output | 8 | Array read data (combinational) |

## Verification
The hardest situation to reach is a second wipe instruction that arrives while a wipe is already running. A restarted timer differs from the original one only in when write-in-progress falls. The bench sends the second instruction right after the first, while the latch is still set. It then times a status read so that the in-progress bit is sampled after the original end but before the end a restart would give. Reset abort is reached in the same way: a wipe is started, reset is pulsed mid-wipe, and a write-enable instruction is clocked in during the recovery window, where it must have no effect.

// File: rtl/wipe_pkg.sv
package wipe_pkg;
   localparam logic [7:0] OP_WREN = 8'h06;
   localparam logic [7:0] OP_RDSR = 8'h05;
   localparam logic [7:0] OP_WIPE = 8'hC7;

   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_WREN = 2'd1,
      CMD_WIPE = 2'd2
   } cmd_e;
endpackage

// File: rtl/wipe_sync.sv
module wipe_sync #(
   parameter int             STAGES = 2,
   parameter int             W      = 3,
   parameter logic [W-1:0]   INIT   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{INIT}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/wipe_rx.sv
module wipe_rx
   import wipe_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hold,
   input  logic       cs_s,
   input  logic       sck_s,
   input  logic       mosi_s,
   input  logic [7:0] status,
   output logic       cs_rise,
   output cmd_e       cmd,
   output logic       out_bit
);
   logic       sck_q, cs_q, rd_q;
   logic [3:0] cnt_q;
   logic [7:0] sh_q;
   logic [2:0] idx_q;
   logic       sck_rise, sck_fall;
   logic [7:0] sh_nx;

   assign sck_rise = sck_s & ~sck_q;
   assign sck_fall = ~sck_s & sck_q;
   assign sh_nx    = {sh_q[6:0], mosi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q   <= 1'b0;
         cs_q    <= 1'b1;
         cnt_q   <= '0;
         sh_q    <= '0;
         rd_q    <= 1'b0;
         idx_q   <= '0;
         out_bit <= 1'b0;
      end else begin
         sck_q <= sck_s;
         cs_q  <= cs_s;
         if (cs_s || hold) begin
            cnt_q <= '0;
            rd_q  <= 1'b0;
            idx_q <= '0;
         end else begin
            if (sck_rise) begin
               sh_q <= sh_nx;
               if (cnt_q != 4'd9) cnt_q <= cnt_q + 4'd1;
               if (cnt_q == 4'd7 && sh_nx == OP_RDSR) rd_q <= 1'b1;
            end
            if (sck_fall && rd_q) begin
               out_bit <= status[~idx_q];
               idx_q   <= idx_q + 3'd1;
            end
         end
      end
   end

   assign cs_rise = cs_s & ~cs_q & ~hold;

   always_comb begin
      cmd = CMD_NONE;
      if (cnt_q == 4'd8) begin
         case (sh_q)
            OP_WREN: cmd = CMD_WREN;
            OP_WIPE: cmd = CMD_WIPE;
            default: cmd = CMD_NONE;
         endcase
      end
   end
endmodule

// File: rtl/wipe_seq.sv
module wipe_seq
   import wipe_pkg::*;
#(
   parameter int ERASE_CYC = 1000,
   parameter int REC_CYC   = 300,
   parameter int TW        = $clog2(ERASE_CYC + 1),
   parameter int RW        = $clog2(REC_CYC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_rise,
   input  cmd_e          cmd,
   input  logic          prot,
   output logic          wip,
   output logic          wel,
   output logic [TW-1:0] tmr,
   output logic          rec_busy
);
   localparam int HALF = ERASE_CYC / 2;

   logic [RW-1:0] rec_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rec_q <= RW'(REC_CYC);
      else if (rec_q != '0) rec_q <= rec_q - 1'b1;
   end
   assign rec_busy = (rec_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wip <= 1'b0;
         wel <= 1'b0;
         tmr <= '0;
      end else if (wip) begin
         tmr <= tmr + 1'b1;
         if (tmr == TW'(HALF - 1))      wel <= 1'b0;
         if (tmr == TW'(ERASE_CYC - 1)) wip <= 1'b0;
      end else if (cs_rise) begin
         case (cmd)
            CMD_WREN: wel <= 1'b1;
            CMD_WIPE: if (wel && !prot) begin
               wip <= 1'b1;
               tmr <= '0;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/wipe_mem.sv
module wipe_mem #(
   parameter int DEPTH = 16,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wipe_we,
   input  logic [AW-1:0] wipe_addr,
   input  logic          ld_en,
   input  logic [AW-1:0] ld_addr,
   input  logic [7:0]    ld_data,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data
);
   logic [7:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wipe_we)    mem_q[wipe_addr] <= 8'hFF;
      else if (ld_en) mem_q[ld_addr]   <= ld_data;
   end

   assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/nor_bulk_wipe.sv
module nor_bulk_wipe
   import wipe_pkg::*;
#(
   parameter int DEPTH       = 16,
   parameter int ERASE_CYC   = 1000,
   parameter int REC_CYC     = 300,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cs_n,
   input  logic                     sck,
   input  logic                     mosi,
   output logic                     miso,
   input  logic                     wp_any,
   input  logic                     ld_en,
   input  logic [$clog2(DEPTH)-1:0] ld_addr,
   input  logic [7:0]               ld_data,
   input  logic [$clog2(DEPTH)-1:0] rd_addr,
   output logic [7:0]               rd_data
);
   localparam int AW = $clog2(DEPTH);
   localparam int TW = $clog2(ERASE_CYC + 1);
   localparam int RW = $clog2(REC_CYC + 1);

   generate
      if (DEPTH < 2)               begin : g_bad_depth $error("DEPTH must be at least 2"); end
      if (ERASE_CYC <= DEPTH)      begin : g_bad_erase $error("ERASE_CYC must exceed DEPTH"); end
      if (REC_CYC < 1)             begin : g_bad_rec   $error("REC_CYC must be at least 1"); end
      if (SYNC_STAGES < 2)         begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
   endgenerate

   logic [2:0] sync_q;
   logic       cs_s, sck_s, mosi_s;
   logic       cs_rise, out_bit;
   cmd_e       cmd;
   logic       wip, wel, rec_busy;
   logic [TW-1:0] tmr;
   logic       wipe_we;

   wipe_sync #(.STAGES(SYNC_STAGES), .W(3), .INIT(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cs_n, sck, mosi}), .q(sync_q)
   );
   assign {cs_s, sck_s, mosi_s} = sync_q;

   wipe_rx u_rx (
      .clk(clk), .rst_n(rst_n), .hold(rec_busy), .cs_s(cs_s), .sck_s(sck_s),
      .mosi_s(mosi_s), .status({6'b0, wel, wip}), .cs_rise(cs_rise),
      .cmd(cmd), .out_bit(out_bit)
   );

   wipe_seq #(.ERASE_CYC(ERASE_CYC), .REC_CYC(REC_CYC), .TW(TW), .RW(RW)) u_seq (
      .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .cmd(cmd), .prot(wp_any),
      .wip(wip), .wel(wel), .tmr(tmr), .rec_busy(rec_busy)
   );

   assign wipe_we = wip && (tmr < TW'(DEPTH));

   wipe_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
      .clk(clk), .wipe_we(wipe_we), .wipe_addr(tmr[AW-1:0]),
      .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   assign miso = cs_s ? 1'bz : out_bit;
endmodule

// File: rtl/wipe_chk.sv
module wipe_chk #(
   parameter int TW = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs_rise,
   input logic          wip,
   input logic          wel,
   input logic          prot,
   input logic          rec_busy,
   input logic [TW-1:0] tmr
);
   p_start_needs_wel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wip) |-> $past(wel));

   p_start_on_cs_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wip) |-> $past(cs_rise));

   p_wel_gone_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wip) |-> !wel);

   p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wip && $past(wip)) |-> (tmr == TW'($past(tmr) + 1'b1)));

   p_prot_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wip) |-> !$past(prot));

   p_recovery_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rec_busy |-> (!wip && !wel));
endmodule

bind nor_bulk_wipe wipe_chk #(.TW(TW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .wip(wip), .wel(wel),
   .prot(wp_any), .rec_busy(rec_busy), .tmr(tmr)
);

// File: tb/sim_nor_bulk_wipe.sv
`timescale 1ns/1ps
module sim_nor_bulk_wipe;
   localparam int DEPTH = 16;
   localparam int ERASE_CYC = 1000;
   localparam int REC_CYC = 300;
   localparam int AW = $clog2(DEPTH);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_any = 1'b0;
   logic ld_en = 1'b0;
   logic [AW-1:0] ld_addr = '0, rd_addr = '0;
   logic [7:0] ld_data = '0;
   wire  [7:0] rd_data;
   wire        miso;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   nor_bulk_wipe #(.DEPTH(DEPTH), .ERASE_CYC(ERASE_CYC), .REC_CYC(REC_CYC)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso),
      .wp_any(wp_any), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   // fields: [9] write-enable first, [8] protect, [7:2] bit count, [1:0] expected {wel,wip}
   localparam logic [9:0] VEC [6] = '{
      {1'b1, 1'b0, 6'd8,  2'b11},
      {1'b0, 1'b0, 6'd8,  2'b00},
      {1'b1, 1'b1, 6'd8,  2'b10},
      {1'b1, 1'b0, 6'd7,  2'b10},
      {1'b1, 1'b0, 6'd9,  2'b10},
      {1'b1, 1'b0, 6'd16, 2'b10}
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic spi(input logic [23:0] tx, input int nbits, output logic [23:0] rx);
      rx = '0;
      cs_n = 1'b0;
      idle(8);
      for (int i = 0; i < nbits; i++) begin
         mosi = tx[23-i];
         idle(6);
         rx = {rx[22:0], miso};
         sck = 1'b1;
         idle(6);
         sck = 1'b0;
      end
      idle(6);
      cs_n = 1'b1;
      idle(8);
   endtask

   task automatic cmd8(input logic [7:0] op);
      logic [23:0] r;
      spi({op, 16'h0}, 8, r);
   endtask

   task automatic rdsr(output logic [7:0] st);
      logic [23:0] r;
      spi({8'h05, 16'h0}, 16, r);
      st = r[7:0];
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(REC_CYC + 10);
   endtask

   task automatic preload(input int seed);
      for (int a = 0; a < DEPTH; a++) begin
         ld_en = 1'b1; ld_addr = AW'(a); ld_data = 8'(seed * 7 + a);
         idle(1);
      end
      ld_en = 1'b0;
      idle(1);
   endtask

   task automatic check_mem(input string tag, input bit wiped, input int seed);
      int bad = 0;
      logic [7:0] exp = '0, act = '0;
      for (int a = 0; a < DEPTH; a++) begin
         rd_addr = AW'(a);
         #1;
         if (rd_data !== (wiped ? 8'hFF : 8'(seed * 7 + a))) begin
            if (bad == 0) begin act = rd_data; exp = wiped ? 8'hFF : 8'(seed * 7 + a); end
            bad++;
         end
      end
      chk(tag, {8'h0, act}, {8'h0, exp});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0]  st;
      logic [23:0] r;
      idle(3);
      rst_n = 1'b1;
      idle(REC_CYC + 10);

      // reset state and R10
      rdsr(st);
      chk("reset status R8", {8'h0, st}, 16'h0000);
      chk("idle hi-z R10", {15'b0, (miso === 1'bz)}, 16'h0001);

      // vector table
      for (int v = 0; v < 6; v++) begin
         do_reset();
         preload(v + 1);
         wp_any = VEC[v][8];
         if (VEC[v][9]) cmd8(8'h06);
         spi({8'hC7, 16'h0}, int'(VEC[v][7:2]), r);
         rdsr(st);
         wp_any = 1'b0;
         chk($sformatf("vector %0d status R2 R3 R7 R4", v), {8'h0, st}, {14'h0, VEC[v][1:0]});
         if (VEC[v][0]) begin
            idle(350);
            rdsr(st);
            chk("wel cleared mid wipe R5", {8'h0, st}, 16'h0001);
            idle(300);
            rdsr(st);
            chk("wipe ended R4", {8'h0, st}, 16'h0000);
            check_mem("array all FF R1", 1'b1, v + 1);
         end else begin
            check_mem($sformatf("vector %0d array untouched R2 R3 R7", v), 1'b0, v + 1);
         end
      end

      // R9: status repeats while clocked, MSB first
      do_reset();
      cmd8(8'h06);
      spi({8'h05, 16'h0}, 24, r);
      chk("status repeats R9", r[15:0], 16'h0202);
      chk("deselected hi-z R10", {15'b0, (miso === 1'bz)}, 16'h0001);

      // R6: wipe while busy does not restart the timer
      do_reset();
      preload(9);
      cmd8(8'h06);
      cmd8(8'hC7);
      idle(10);
      cmd8(8'hC7);
      idle(860 - 128);
      rdsr(st);
      chk("busy wipe ignored R6", {8'h0, st}, 16'h0000);
      check_mem("array FF after busy R6 R1", 1'b1, 9);

      // R8: reset aborts, recovery ignores instructions
      do_reset();
      cmd8(8'h06);
      cmd8(8'hC7);
      idle(100);
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      cmd8(8'h06);
      idle(REC_CYC);
      rdsr(st);
      chk("abort and recovery ignore R8", {8'h0, st}, 16'h0000);
      cmd8(8'h06);
      rdsr(st);
      chk("write enable after recovery R2 R8", {8'h0, st}, 16'h0002);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule